// File: doc/BRIEF.md
# Serial display PLL bring-up sequencer

This block brings a serial display link and its PLL out of power-down without any software polling. A one-cycle start pulse begins a fixed sequence. The block enables the free-running pixel clock and releases the PLL from reset. After a short settle interval it issues a PLL go request. It then waits for three status inputs in turn: go-busy low, PLL lock high, and link reset done high. Between the lock and link-done waits it enables the LCD output. Each wait has its own timeout counter. When the link comes up, the block raises a done flag.

If a wait times out, the block backs out the outputs it raised, in reverse order, one output per cycle, and then raises a sticky error flag. A disable input takes a running or completed link down in a fixed order. The PLL and the link are external. They only report status to the block.

Top module: `sdpll_bringup`

## Requirements
- R1: While the synchronous active-high reset is asserted, every output is low, and they stay low after reset until a start pulse arrives.
- R2: A start pulse sampled in idle raises the pixel clock enable on that edge and the PLL reset release one cycle later.
- R3: The go request rises SETTLE_CYC cycles after the reset release. It falls on the edge that first samples go-busy low.
- R4: The lock input is examined only after go has been cleared. The LCD enable rises on the edge that first samples lock high in that wait, even if lock was already high earlier.
- R5: Done rises on the edge that samples link-done high while the LCD enable is high. Done stays high until a disable, and it is never high together with error.
- R6: If go-busy stays high for TMO_CYC sampled edges, the block clears go on that edge. It clears the reset release one cycle later, then the pixel clock enable one cycle after that, and raises error on that same edge. A lock timeout after TMO_CYC edges gives the same reset-release and clock teardown, starting one cycle after the expiry edge.
- R7: A link-done timeout after TMO_CYC edges clears the LCD enable one cycle after expiry. It then clears the reset release on the next cycle, and clears the pixel clock enable and raises error on the cycle after that.
- R8: A disable sampled while a sequence runs, or while the link is up, clears the LCD enable, done and go on that edge. It clears the pixel clock enable on the next edge and the reset release on the edge after that.
- R9: A start pulse sampled outside idle has no effect on any output.
- R10: Error stays high until the next accepted start, which clears it on the edge that raises the pixel clock enable.
- R11: Disable takes priority over a wait that expires on the same edge, and no error is raised. A disable sampled in idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse |
| disable_i | input | 1 | Tear-down command |
| busy_i | input | 1 | PLL go request still busy |
| lock_i | input | 1 | PLL locked |
| link_ok_i | input | 1 | Link reset complete |
| pclk_en_o | output | 1 | Free-running pixel clock enable |
| pll_rel_o | output | 1 | PLL reset release |
| pll_go_o | output | 1 | PLL go request |
| lcd_en_o | output | 1 | LCD output enable |
| done_o | output | 1 | Link up |
| err_o | output | 1 | Sticky timeout error |

## Verification
The link-done wait can expire on the same edge that a disable is sampled. The bench provokes this by driving disable so that the block samples it on exactly the TMO_CYC-th edge of that wait. It then expects the disable order (LCD enable, then pixel clock enable, then reset release) with no error, instead of the three-step unwind that ends in error. In a second collision, start is pulsed while the lock wait is pending. The bench judges this by the absence of any output change. A scoreboard predicts each output change and the cycle in which it should happen.

// File: rtl/sdpll_bringup.sv
module sdpll_bringup #(
  parameter int SETTLE_CYC = 2,
  parameter int TMO_CYC    = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic disable_i,
  input  logic busy_i,
  input  logic lock_i,
  input  logic link_ok_i,
  output logic pclk_en_o,
  output logic pll_rel_o,
  output logic pll_go_o,
  output logic lcd_en_o,
  output logic done_o,
  output logic err_o
);
  localparam int MAXC = (TMO_CYC > SETTLE_CYC) ? TMO_CYC : SETTLE_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_REL, S_SETTLE, S_BUSY, S_LOCK, S_LINK, S_UP,
    S_UNW_LCD, S_UNW_REL, S_UNW_CLK, S_DIS_CLK, S_DIS_REL
  } state_t;

  state_t        st;
  logic [CW-1:0] cnt;
  logic          expired, can_dis;

  assign expired = (cnt == CW'(TMO_CYC - 1));
  assign can_dis = st inside {S_REL, S_SETTLE, S_BUSY, S_LOCK, S_LINK, S_UP};

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; cnt <= '0;
      pclk_en_o <= 1'b0; pll_rel_o <= 1'b0; pll_go_o <= 1'b0;
      lcd_en_o <= 1'b0; done_o <= 1'b0; err_o <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start_i) begin
          pclk_en_o <= 1'b1; done_o <= 1'b0; err_o <= 1'b0; st <= S_REL;
        end
        S_REL: begin pll_rel_o <= 1'b1; cnt <= '0; st <= S_SETTLE; end
        S_SETTLE:
          if (cnt == CW'(SETTLE_CYC - 1)) begin
            pll_go_o <= 1'b1; cnt <= '0; st <= S_BUSY;
          end else cnt <= cnt + 1'b1;
        S_BUSY:
          if (!busy_i) begin pll_go_o <= 1'b0; cnt <= '0; st <= S_LOCK; end
          else if (expired) begin pll_go_o <= 1'b0; st <= S_UNW_REL; end
          else cnt <= cnt + 1'b1;
        S_LOCK:
          if (lock_i) begin lcd_en_o <= 1'b1; cnt <= '0; st <= S_LINK; end
          else if (expired) st <= S_UNW_REL;
          else cnt <= cnt + 1'b1;
        S_LINK:
          if (link_ok_i) begin done_o <= 1'b1; st <= S_UP; end
          else if (expired) st <= S_UNW_LCD;
          else cnt <= cnt + 1'b1;
        S_UP: ;
        S_UNW_LCD: begin lcd_en_o <= 1'b0; st <= S_UNW_REL; end
        S_UNW_REL: begin pll_rel_o <= 1'b0; st <= S_UNW_CLK; end
        S_UNW_CLK: begin pclk_en_o <= 1'b0; err_o <= 1'b1; st <= S_IDLE; end
        S_DIS_CLK: begin pclk_en_o <= 1'b0; st <= S_DIS_REL; end
        S_DIS_REL: begin pll_rel_o <= 1'b0; st <= S_IDLE; end
        default: st <= S_IDLE;
      endcase
      if (disable_i && can_dis) begin
        lcd_en_o <= 1'b0; done_o <= 1'b0; pll_go_o <= 1'b0; st <= S_DIS_CLK;
      end
    end
  end

  p_go_after_rel_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(pll_go_o) |-> $past(pll_rel_o) && pll_rel_o && pclk_en_o);

  p_lcd_needs_pll_r4: assert property (@(posedge clk) disable iff (rst)
    lcd_en_o |-> pll_rel_o && pclk_en_o && !pll_go_o);

  p_done_on_link_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(link_ok_i) && lcd_en_o);

  p_done_err_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(done_o && err_o));

  p_err_clean_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(err_o) |-> !pclk_en_o && !pll_rel_o && !pll_go_o && !lcd_en_o);

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (err_o && !start_i) |=> err_o);
endmodule

// File: tb/sdpll_bringup_tb.sv
module sdpll_bringup_tb;
  localparam int TMO = 20;
  localparam int SET = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic start_i = 1'b0, disable_i = 1'b0;
  logic busy_i = 1'b1, lock_i = 1'b0, link_ok_i = 1'b0;
  logic pclk_en_o, pll_rel_o, pll_go_o, lcd_en_o, done_o, err_o;

  always #2 clk = ~clk;

  sdpll_bringup #(.SETTLE_CYC(SET), .TMO_CYC(TMO)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .disable_i(disable_i),
    .busy_i(busy_i), .lock_i(lock_i), .link_ok_i(link_ok_i),
    .pclk_en_o(pclk_en_o), .pll_rel_o(pll_rel_o), .pll_go_o(pll_go_o),
    .lcd_en_o(lcd_en_o), .done_o(done_o), .err_o(err_o));

  typedef struct { int cyc; logic [5:0] vec; string req; } item_t;
  item_t q[$];
  int cyc = 0, checks = 0, fails = 0;
  logic [5:0] evec = '0, prev = '0;
  logic e_clk = 0, e_rel = 0, e_go = 0, e_lcd = 0, e_done = 0, e_err = 0;

  always @(posedge clk) cyc <= cyc + 1;

  wire [5:0] vec = {pclk_en_o, pll_rel_o, pll_go_o, lcd_en_o, done_o, err_o};

  task automatic push(input int c, input string r);
    logic [5:0] v;
    item_t it;
    v = {e_clk, e_rel, e_go, e_lcd, e_done, e_err};
    if (v != evec) begin
      it.cyc = c; it.vec = v; it.req = r;
      q.push_back(it);
      evec = v;
    end
  endtask

  always @(negedge clk) if (!rst) begin
    if (vec != prev) begin
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL unexpected change cyc %0d actual %b expected no change", cyc, vec);
      end else begin
        item_t it;
        it = q.pop_front();
        if (it.cyc != cyc || it.vec != vec) begin
          fails++;
          $display("FAIL %s actual cyc %0d vec %b expected cyc %0d vec %b",
                   it.req, cyc, vec, it.cyc, it.vec);
        end
      end
      prev = vec;
    end
  end

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic pulse_start();
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
  endtask

  // mode: 0 ok, 1 busy tmo, 2 lock tmo, 3 link tmo, 4 disable at link expiry, 5 start in lock wait
  task automatic seq(input int db, input int dl, input int dk, input int mode, input bit lock_early);
    int p, g, l, d, c2;
    @(negedge clk);
    p = cyc + 1;
    if (lock_early) lock_i = 1'b1;
    pulse_start();
    e_clk = 1; e_err = 0; e_done = 0; push(p, "R2/R10");
    e_rel = 1; push(p + 1, "R2");
    e_go = 1;  push(p + 1 + SET, "R3");
    if (mode == 1) begin
      e_go = 0;  push(p + 1 + SET + TMO, "R6 busy-timeout go");
      e_rel = 0; push(p + 2 + SET + TMO, "R6 busy-timeout rel");
      e_clk = 0; e_err = 1; push(p + 3 + SET + TMO, "R6 busy-timeout clk/err");
      wait_to(p + SET + TMO + 8);
    end else begin
      wait_to(p + 1 + SET + db); busy_i = 1'b0;
      g = p + 2 + SET + db;
      e_go = 0; push(g, "R3 go clear");
      if (mode == 2) begin
        e_rel = 0; push(g + TMO + 1, "R6 lock-timeout rel");
        e_clk = 0; e_err = 1; push(g + TMO + 2, "R6 lock-timeout clk/err");
        wait_to(g + TMO + 6);
      end else begin
        if (mode == 5) begin wait_to(g + 1); pulse_start(); end
        wait_to(g + dl); lock_i = 1'b1;
        l = g + dl + 1;
        e_lcd = 1; push(l, "R4");
        if (mode == 3) begin
          e_lcd = 0; push(l + TMO + 1, "R7 lcd");
          e_rel = 0; push(l + TMO + 2, "R7 rel");
          e_clk = 0; e_err = 1; push(l + TMO + 3, "R7 clk/err");
          wait_to(l + TMO + 7);
        end else if (mode == 4) begin
          wait_to(l + TMO - 1); disable_i = 1'b1; @(negedge clk); disable_i = 1'b0;
          e_lcd = 0; push(l + TMO, "R11 disable wins lcd");
          e_clk = 0; push(l + TMO + 1, "R11 clk");
          e_rel = 0; push(l + TMO + 2, "R11 rel no err");
          wait_to(l + TMO + 6);
        end else begin
          wait_to(l + dk); link_ok_i = 1'b1;
          d = l + dk + 1;
          e_done = 1; push(d, "R5");
          wait_to(d + 2); pulse_start();          // R9 start while up
          wait_to(d + 5); c2 = cyc;
          disable_i = 1'b1; @(negedge clk); disable_i = 1'b0;
          e_lcd = 0; e_done = 0; push(c2 + 1, "R8 lcd/done");
          e_clk = 0; push(c2 + 2, "R8 clk");
          e_rel = 0; push(c2 + 3, "R8 rel");
          wait_to(c2 + 7);
        end
      end
    end
    busy_i = 1'b1; lock_i = 1'b0; link_ok_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R1-pending actual %0d items expected 0", q.size());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (vec !== 6'b0) begin
      fails++; $display("FAIL R1 actual %b expected 000000", vec);
    end
    rst = 1'b0;
    repeat (4) @(negedge clk);
    checks++;
    if (vec !== 6'b0) begin
      fails++; $display("FAIL R1 after release actual %b expected 000000", vec);
    end
    disable_i = 1'b1; @(negedge clk); disable_i = 1'b0;   // R11 disable in idle
    repeat (3) @(negedge clk);
    seq(3, 2, 4, 0, 1'b0);
    seq(0, 0, 0, 0, 1'b1);
    seq(0, 0, 0, 1, 1'b0);
    seq(2, 0, 0, 2, 1'b0);
    seq(1, 1, 0, 3, 1'b0);
    seq(1, 1, 0, 4, 1'b0);
    seq(2, 5, 2, 5, 1'b0);
    repeat (5) @(negedge clk);
    summary();
    $finish;
  end
endmodule